// File: doc/BRIEF.md
# Fixed-Priority Eight-Input Interrupt Prioritizer

This block collects up to eight interrupt request lines, remembers each rising request in a pending register, and raises a single interrupt output toward the processor while anything is pending. The processor (or the bridge in front of it) answers with a two-pulse active-low acknowledge. The first pulse picks the lowest-numbered pending request, moves it into the in-service register and removes it from the pending set. The second pulse places an 8-bit vector on a dedicated vector output. The vector is built from a fixed base with its low bits replaced by the request number.

Software that cannot produce acknowledge pulses uses a byte-wide command port instead. A poll command turns the next command-port read into an acknowledge that returns the winning request number and a pending flag. Two other command bytes choose whether plain reads return the pending or the in-service register. A non-specific end-of-interrupt byte retires the highest-priority request that is in service. If an acknowledge of either kind finds nothing pending, the block reports the lowest-priority number and leaves the in-service register untouched, so software can recognise the event as spurious.

Top module: `pic_ctrl`

## Requirements
- R1: A low-to-high change on `irq_i[k]` (compared with its value at the previous clock edge) sets pending bit k. `int_o` is high exactly when the pending register is non-zero, and it changes one clock after the edge that samples the request.
- R2: At the first `inta_n_i` falling edge of a pair (a low sample after a high sample), the lowest-numbered pending bit is cleared from the pending register and set in the in-service register, so at most one in-service bit appears per edge. A new rising request on that same bit in that same cycle leaves the pending bit set.
- R3: At the second falling edge of the pair, `vec_oe_o` goes high one clock later and stays high until one clock after `inta_n_i` is sampled high. While it is high, `vec_o` equals `VEC_BASE` (default 0x08) with bits 2:0 replaced by the number chosen at the first edge.
- R4: A command write of 0x0A selects the pending register and 0x0B selects the in-service register for later plain reads. The selection after reset is the pending register. A read strobe `cmd_re_i` loads `cmd_rdata_o` at that clock edge, and the value holds until the next read.
- R5: A command write of 0x0C arms poll. The next read acts as an acknowledge (same effect on the registers as R2) and returns bit 7 = 1 if anything was pending, bits 6:3 = 0 and bits 2:0 = request number. It then disarms poll and selects the in-service register for later plain reads.
- R6: An acknowledge (pulse or poll read) with nothing pending reports number 7 (vector 0x0F by default, poll data 0x07) and changes no in-service bit.
- R7: A command write of 0x20 clears the lowest-numbered set in-service bit. It has no effect when the in-service register is zero.
- R8: Command bytes other than 0x0A, 0x0B, 0x0C and 0x20 change neither the read selection nor the poll state.
- R9: When a first acknowledge pulse edge and an armed poll read happen in the same cycle, the pulse is the acknowledge. The read returns plain readback and poll stays armed.
- R10: After reset the pending and in-service registers are zero, `int_o`, `vec_oe_o` and `cmd_rdata_o` are zero, and poll is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_REQ | Request lines, rising edge latched |
| int_o | output | 1 | Interrupt to the processor, high while anything is pending |
| inta_n_i | input | 1 | Active-low acknowledge pulses, sampled on the clock |
| vec_o | output | 8 | Vector presented after the second acknowledge pulse |
| vec_oe_o | output | 1 | Vector output enable |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_re_i | input | 1 | Command port read strobe |
| cmd_wdata_i | input | 8 | Command byte |
| cmd_rdata_o | output | 8 | Registered command port read data |

## Verification
A wrong pending bit shows at `int_o` one clock after it goes wrong, and it shows in the number carried by the next vector or poll read. A wrong in-service bit stays hidden until software reads the in-service register or sends an end-of-interrupt, so the bench reads it back after every acknowledge and after every end-of-interrupt. A wrong acknowledge phase or poll flag shows at the next pulse or read as a vector that appears at the wrong time or as poll data in place of register data. A behavioural model compared on every clock catches each of these within a few cycles of the stimulus that exposes it.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int DATA_W = 8;

   localparam logic [DATA_W-1:0] CMD_SEL_PEND = 8'h0A;
   localparam logic [DATA_W-1:0] CMD_SEL_SERV = 8'h0B;
   localparam logic [DATA_W-1:0] CMD_POLL     = 8'h0C;
   localparam logic [DATA_W-1:0] CMD_EOI      = 8'h20;

   typedef enum logic {
      RD_PEND = 1'b0,
      RD_SERV = 1'b1
   } rdsel_e;

   typedef enum logic {
      ACK_FIRST  = 1'b0,
      ACK_SECOND = 1'b1
   } ackph_e;
endpackage

// File: rtl/pic_prio_resolver.sv
// Lowest-index-first selector; STYLE picks ripple chain (0) or two's complement (1).
module pic_prio_resolver #(
   parameter int W     = 8,
   parameter int STYLE = 0,
   localparam int IW   = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   output logic [W-1:0]  grant_oh,
   output logic [IW-1:0] grant_idx,
   output logic          any
);
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("pic_prio_resolver: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_ripple
      logic [W-1:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign grant_oh[i] = req[i] & ~seen[i];
         if (i < W - 1) begin : g_chain
            assign seen[i+1] = seen[i] | req[i];
         end
      end
   end else begin : g_twos
      assign grant_oh = req & (~req + {{(W-1){1'b0}}, 1'b1});
   end

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < W; i++) begin
         if (grant_oh[i]) grant_idx = grant_idx | IW'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/pic_req_latch.sv
// Edge capture of the request lines into the pending register.
module pic_req_latch #(
   parameter int NUM_REQ = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] irq_i,
   input  logic [NUM_REQ-1:0] clr_mask,
   output logic [NUM_REQ-1:0] pend_q
);
   logic [NUM_REQ-1:0] irq_prev_q;
   logic [NUM_REQ-1:0] rise;

   assign rise = irq_i & ~irq_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_prev_q <= '0;
         pend_q     <= '0;
      end else begin
         irq_prev_q <= irq_i;
         pend_q     <= (pend_q & ~clr_mask) | rise;
      end
   end
endmodule

// File: rtl/pic_ack_seq.sv
// Two-pulse acknowledge sequencer and vector driver.
module pic_ack_seq import pic_pkg::*; #(
   parameter int          IW       = 3,
   parameter logic [7:0]  VEC_BASE = 8'h08
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inta_n_i,
   input  logic [IW-1:0] num,
   output logic          ack_first,
   output logic [7:0]    vec_o,
   output logic          vec_oe_o
);
   logic          inta_prev_q;
   ackph_e        phase_q;
   logic [IW-1:0] num_q;
   logic          fall;
   logic          vec_ev;

   assign fall      = inta_prev_q & ~inta_n_i;
   assign ack_first = fall && (phase_q == ACK_FIRST);
   assign vec_ev    = fall && (phase_q == ACK_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inta_prev_q <= 1'b1;
         phase_q     <= ACK_FIRST;
         num_q       <= '0;
         vec_o       <= '0;
         vec_oe_o    <= 1'b0;
      end else begin
         inta_prev_q <= inta_n_i;
         if (ack_first) begin
            phase_q <= ACK_SECOND;
            num_q   <= num;
         end else if (vec_ev) begin
            phase_q <= ACK_FIRST;
         end
         if (vec_ev) begin
            vec_o    <= {VEC_BASE[7:IW], num_q};
            vec_oe_o <= 1'b1;
         end else if (inta_n_i) begin
            vec_oe_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pic_cmd_port.sv
// Command decode, poll handling and registered readback.
module pic_cmd_port import pic_pkg::*; #(
   parameter int NUM_REQ = 8,
   localparam int IW     = $clog2(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_we_i,
   input  logic               cmd_re_i,
   input  logic [DATA_W-1:0]  cmd_wdata_i,
   input  logic               ack_first,
   input  logic [NUM_REQ-1:0] pend,
   input  logic [NUM_REQ-1:0] serv,
   input  logic               any_pend,
   input  logic [IW-1:0]      num,
   output logic               poll_ack,
   output logic               eoi,
   output logic               poll_armed,
   output logic [DATA_W-1:0]  cmd_rdata_o
);
   rdsel_e            sel_q;
   logic              poll_q;
   logic [DATA_W-1:0] poll_word;
   logic [DATA_W-1:0] plain_word;

   assign poll_armed = poll_q;
   assign poll_ack   = cmd_re_i & poll_q & ~ack_first;
   assign eoi        = cmd_we_i && (cmd_wdata_i == CMD_EOI);

   always_comb begin
      poll_word            = '0;
      poll_word[DATA_W-1]  = any_pend;
      poll_word[IW-1:0]    = num;
      plain_word = (sel_q == RD_SERV) ? DATA_W'(serv) : DATA_W'(pend);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q       <= RD_PEND;
         poll_q      <= 1'b0;
         cmd_rdata_o <= '0;
      end else begin
         if (poll_ack) begin
            poll_q <= 1'b0;
            sel_q  <= RD_SERV;
         end
         if (cmd_we_i) begin
            case (cmd_wdata_i)
               CMD_SEL_PEND: sel_q  <= RD_PEND;
               CMD_SEL_SERV: sel_q  <= RD_SERV;
               CMD_POLL:     poll_q <= 1'b1;
               default: ;
            endcase
         end
         if (cmd_re_i) begin
            cmd_rdata_o <= poll_ack ? poll_word : plain_word;
         end
      end
   end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl import pic_pkg::*; #(
   parameter int         NUM_REQ    = 8,
   parameter logic [7:0] VEC_BASE   = 8'h08,
   parameter int         PRIO_STYLE = 0,
   localparam int        IW         = $clog2(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] irq_i,
   output logic               int_o,
   input  logic               inta_n_i,
   output logic [7:0]         vec_o,
   output logic               vec_oe_o,
   input  logic               cmd_we_i,
   input  logic               cmd_re_i,
   input  logic [7:0]         cmd_wdata_i,
   output logic [7:0]         cmd_rdata_o
);
   if (NUM_REQ < 2 || NUM_REQ > 8 || (1 << IW) != NUM_REQ) begin : g_bad_num
      $error("pic_ctrl: NUM_REQ must be a power of two from 2 to 8");
   end

   localparam logic [IW-1:0] SPUR_NUM = IW'(NUM_REQ - 1);

   logic [NUM_REQ-1:0] pend_q;
   logic [NUM_REQ-1:0] serv_q;
   logic [NUM_REQ-1:0] pend_oh;
   logic [NUM_REQ-1:0] serv_oh;
   logic [IW-1:0]      pend_idx;
   logic [IW-1:0]      serv_idx;
   logic               any_pend;
   logic               any_serv;
   logic [IW-1:0]      num;
   logic               ack_first;
   logic               poll_ack;
   logic               ack_any;
   logic               eoi;
   logic               poll_armed;
   logic [NUM_REQ-1:0] take_mask;
   logic [NUM_REQ-1:0] retire_mask;

   pic_prio_resolver #(.W(NUM_REQ), .STYLE(PRIO_STYLE)) u_pend_prio (
      .req(pend_q), .grant_oh(pend_oh), .grant_idx(pend_idx), .any(any_pend)
   );

   pic_prio_resolver #(.W(NUM_REQ), .STYLE(PRIO_STYLE)) u_serv_prio (
      .req(serv_q), .grant_oh(serv_oh), .grant_idx(serv_idx), .any(any_serv)
   );

   assign num         = any_pend ? pend_idx : SPUR_NUM;
   assign ack_any     = ack_first | poll_ack;
   assign take_mask   = (ack_any && any_pend) ? pend_oh : '0;
   assign retire_mask = (eoi && any_serv) ? serv_oh : '0;
   assign int_o       = any_pend;

   pic_req_latch #(.NUM_REQ(NUM_REQ)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_mask(take_mask), .pend_q(pend_q)
   );

   pic_ack_seq #(.IW(IW), .VEC_BASE(VEC_BASE)) u_ack (
      .clk(clk), .rst_n(rst_n), .inta_n_i(inta_n_i), .num(num),
      .ack_first(ack_first), .vec_o(vec_o), .vec_oe_o(vec_oe_o)
   );

   pic_cmd_port #(.NUM_REQ(NUM_REQ)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we_i), .cmd_re_i(cmd_re_i),
      .cmd_wdata_i(cmd_wdata_i), .ack_first(ack_first), .pend(pend_q),
      .serv(serv_q), .any_pend(any_pend), .num(num), .poll_ack(poll_ack),
      .eoi(eoi), .poll_armed(poll_armed), .cmd_rdata_o(cmd_rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) serv_q <= '0;
      else        serv_q <= (serv_q & ~retire_mask) | take_mask;
   end
endmodule

// File: rtl/pic_ctrl_checker.sv
module pic_ctrl_checker #(
   parameter int NUM_REQ = 8,
   localparam int IW     = $clog2(NUM_REQ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] irq_i,
   input logic               int_o,
   input logic               inta_n_i,
   input logic               vec_oe_o,
   input logic               cmd_we_i,
   input logic               cmd_re_i,
   input logic [7:0]         cmd_wdata_i,
   input logic [7:0]         cmd_rdata_o,
   input logic [NUM_REQ-1:0] serv_q,
   input logic               ack_any,
   input logic               ack_first,
   input logic               poll_armed
);
   assert_rise_raises_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_i & ~$past(irq_i)) != '0) |=> int_o);

   assert_one_new_service_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(serv_q & ~$past(serv_q)) <= 1);

   assert_vec_only_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> $past(!inta_n_i));

   assert_poll_zero_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_re_i && poll_armed && !ack_first) |=> (cmd_rdata_o[6:IW] == '0));

   assert_spurious_no_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_any && !int_o && !(cmd_we_i && cmd_wdata_i == 8'h20)) |=> $stable(serv_q));

   assert_eoi_retires_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && cmd_wdata_i == 8'h20 && serv_q != '0 && !ack_any)
      |=> ($countones(serv_q) == $countones($past(serv_q)) - 1));

   assert_pulse_keeps_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_first && cmd_re_i && poll_armed) |=> poll_armed);
endmodule

bind pic_ctrl pic_ctrl_checker #(.NUM_REQ(NUM_REQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .int_o(int_o), .inta_n_i(inta_n_i),
   .vec_oe_o(vec_oe_o), .cmd_we_i(cmd_we_i), .cmd_re_i(cmd_re_i),
   .cmd_wdata_i(cmd_wdata_i), .cmd_rdata_o(cmd_rdata_o), .serv_q(serv_q),
   .ack_any(ack_any), .ack_first(ack_first), .poll_armed(poll_armed)
);

// File: tb/tb_pic_ctrl.sv
`timescale 1ns/1ps
module tb_pic_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       int_o;
   logic       inta_n = 1'b1;
   logic [7:0] vec_o;
   logic       vec_oe;
   logic       we = 1'b0;
   logic       re = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pic_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .int_o(int_o), .inta_n_i(inta_n),
      .vec_o(vec_o), .vec_oe_o(vec_oe), .cmd_we_i(we), .cmd_re_i(re),
      .cmd_wdata_i(wdata), .cmd_rdata_o(rdata)
   );

   // Behavioural reference model
   logic [7:0] m_pend, m_serv, m_prev_irq, m_vec, m_rdata;
   bit         m_prev_inta, m_second, m_vecoe, m_sel_serv, m_poll;
   int         m_num;

   function automatic int lowest(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_serv = 0; m_prev_irq = 0; m_vec = 0; m_rdata = 0;
         m_prev_inta = 1; m_second = 0; m_vecoe = 0; m_sel_serv = 0; m_poll = 0; m_num = 0;
      end else begin
         logic [7:0] rise, take, retire, pword;
         bit fall, first, second, pollrd;
         int w, s, n;
         rise   = irq & ~m_prev_irq;
         fall   = m_prev_inta && !inta_n;
         first  = fall && !m_second;
         second = fall && m_second;
         pollrd = re && m_poll && !first;
         w = lowest(m_pend);
         n = (w < 0) ? 7 : w;
         take = 0;
         if ((first || pollrd) && w >= 0) take[w] = 1'b1;
         retire = 0;
         s = lowest(m_serv);
         if (we && wdata == 8'h20 && s >= 0) retire[s] = 1'b1;
         pword = {(w >= 0), 4'b0000, 3'(n)};
         if (re) m_rdata = pollrd ? pword : (m_sel_serv ? m_serv : m_pend);
         if (second) begin m_vec = {5'b00001, 3'(m_num)}; m_vecoe = 1; end
         else if (inta_n) m_vecoe = 0;
         if (first) begin m_second = 1; m_num = n; end
         else if (second) m_second = 0;
         if (pollrd) begin m_poll = 0; m_sel_serv = 1; end
         if (we) begin
            if (wdata == 8'h0A) m_sel_serv = 0;
            else if (wdata == 8'h0B) m_sel_serv = 1;
            else if (wdata == 8'h0C) m_poll = 1;
         end
         m_pend = (m_pend & ~take) | rise;
         m_serv = (m_serv & ~retire) | take;
         m_prev_irq = irq;
         m_prev_inta = inta_n;
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && !done) begin
         chk("R1 int_o model", {7'b0, int_o}, {7'b0, |m_pend});
         chk("R3 vec_oe model", {7'b0, vec_oe}, {7'b0, m_vecoe});
         if (vec_oe) chk("R3 vec_o model", vec_o, m_vec);
         chk("R4 rdata model", rdata, m_rdata);
      end
   end

   task automatic cyc(); @(negedge clk); endtask
   task automatic cmd(logic [7:0] b); we = 1; wdata = b; cyc(); we = 0; endtask
   task automatic rd(); re = 1; cyc(); re = 0; endtask
   task automatic pulse(); inta_n = 0; cyc(); inta_n = 1; cyc(); endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      model_on = 1;
      // R10 reset state
      chk("R10 int_o", {7'b0, int_o}, 8'h00);
      chk("R10 vec_oe", {7'b0, vec_oe}, 8'h00);
      chk("R10 rdata", rdata, 8'h00);
      // R1 latch
      irq = 8'h28; cyc();
      chk("R1 int after rise", {7'b0, int_o}, 8'h01);
      rd(); chk("R4 default pending readback", rdata, 8'h28);
      // R2 / R3 acknowledge pair
      inta_n = 0; cyc(); inta_n = 1; cyc();
      inta_n = 0; cyc();
      chk("R3 vec_oe after second pulse", {7'b0, vec_oe}, 8'h01);
      chk("R3 vector", vec_o, 8'h0B);
      inta_n = 1; cyc();
      chk("R3 vec_oe drops", {7'b0, vec_oe}, 8'h00);
      cmd(8'h0B); rd(); chk("R2 service after ack", rdata, 8'h08);
      cmd(8'h0A); rd(); chk("R2 pending after ack", rdata, 8'h20);
      // R7 end of interrupt
      cmd(8'h20); cmd(8'h0B); rd(); chk("R7 eoi clears", rdata, 8'h00);
      cmd(8'h20); rd(); chk("R7 eoi on empty", rdata, 8'h00);
      // R5 poll
      cmd(8'h0C); rd(); chk("R5 poll word", rdata, 8'h85);
      chk("R1 int low when empty", {7'b0, int_o}, 8'h00);
      rd(); chk("R5 after poll selects service", rdata, 8'h20);
      // R8 ignored byte
      cmd(8'hFF); rd(); chk("R8 ignored byte", rdata, 8'h20);
      // R6 spurious
      cmd(8'h20); cmd(8'h0C); rd(); chk("R6 poll spurious", rdata, 8'h07);
      rd(); chk("R6 service unchanged", rdata, 8'h00);
      pulse(); inta_n = 0; cyc();
      chk("R6 spurious vector", vec_o, 8'h0F);
      inta_n = 1; cyc();
      rd(); chk("R6 service still empty", rdata, 8'h00);
      // R9 pulse and poll read together
      irq = 8'h00; cyc(); irq = 8'h02; cyc();
      cmd(8'h0C);
      inta_n = 0; re = 1; cyc(); re = 0; inta_n = 1;
      chk("R9 plain readback", rdata, 8'h00);
      cyc(); inta_n = 0; cyc(); inta_n = 1;
      chk("R9 vector", vec_o, 8'h09);
      cyc(); rd(); chk("R9 poll still armed", rdata, 8'h07);
      rd(); chk("R2 service from pulse", rdata, 8'h02);
      // random stimulus against model
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 20) irq[$urandom_range(0, 7)] ^= 1'b1;
         inta_n = ($urandom_range(0, 3) != 0);
         we = ($urandom_range(0, 5) == 0);
         re = ($urandom_range(0, 4) == 0);
         case ($urandom_range(0, 5))
            0: wdata = 8'h0A;
            1: wdata = 8'h0B;
            2: wdata = 8'h0C;
            3: wdata = 8'h20;
            4: wdata = 8'h20;
            default: wdata = 8'($urandom);
         endcase
         cyc();
      end
      we = 0; re = 0; inta_n = 1;
      repeat (3) cyc();
      finish_run();
   end
endmodule